// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves like a small serial EEPROM with 512 words of 16 bits. It sits behind a three-wire serial link with a select line, a serial clock and a data input. Its output is split into a data bit and an output enable, so that a pad or a shared data line can be driven from it. A faster system clock samples the serial lines through synchronizers, and all decoding acts on the edges it detects.

An instruction is a start bit, a two-bit opcode and a ten-bit address. A read first returns a zero, then the addressed word. It keeps streaming the following words for as long as the link stays selected, and wraps from the last address to the first. A write or an erase is committed when the select line falls. A self-timed cycle then runs for a fixed number of system clocks. A master that selects the device during that cycle sees a low output while the cycle runs and a high output once it is done. Shifting a one in during this status display releases the output.

Top module: `sw_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, no self-timed cycle is running, and writes are disabled. A WRITE issued before any enable leaves memory unchanged.
- R2: Data input is sampled on serial-clock rising edges while selected. Zeros before the first one are ignored. The one is followed by the opcode and a 10-bit address, both sent MSB first. Address bit 9 is ignored by READ, WRITE and ERASE.
- R3: READ (opcode 10) drives the output enable high on the rising edge that takes the last address bit and shows a zero there. Each following rising edge then shows one bit of the addressed word, MSB first.
- R4: While the link stays selected, a read goes on to the next word without a leading zero, and address 511 is followed by address 0.
- R5: WRITE (opcode 01) takes 16 data bits, MSB first, and stores them at the falling edge of select. No erase is needed first.
- R6: ERASE (opcode 11) sets the addressed word to 16'hFFFF at the falling edge of select.
- R7: Opcode 00 with address bits [9:8] = 11 enables writes; with 00 it disables them. While writes are disabled, WRITE and ERASE have no effect.
- R8: If select falls before a WRITE has all 16 data bits, nothing is stored.
- R9: A committed write or erase keeps the device busy for WRITE_CYCLES system clocks. If the device is selected while busy, the output is enabled and shows 0. It shows 1 once the cycle has ended.
- R10: While the status is shown, shifting a 1 into data input turns the output enable low after the next serial-clock falling edge.
- R11: An instruction shifted in during a selection that began while busy is ignored.
- R12: When select is low, the output enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select line, active high |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output value |
| doe_o | output | 1 | Output enable for dout_o (low means high impedance) |

## Verification
The bench builds the block with WRITE_CYCLES set to 40 instead of the default 1000. With that value a single serial bit time covers a sizeable part of the busy window. The busy-low status, the release by a shifted one, and the change to ready can all be seen within one selection. The address and data widths keep their defaults, so the wrap from word 511 to word 0 is exercised on the full 9-bit address space.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_DATA,
    S_READ,
    S_HOLD,
    S_STATUS
  } st_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eep_timer.sv
module eep_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sw_eeprom_slave.sv
module sw_eeprom_slave #(
  parameter int ADDR_W       = 9,
  parameter int ADDR_FIELD   = 10,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic dout_o,
  output logic doe_o
);
  import eep_pkg::*;

  localparam int OP_W   = 2;
  localparam int MAXLEN = (DATA_W > ADDR_FIELD) ? DATA_W : ADDR_FIELD;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int BIDX_W = $clog2(DATA_W);

  // synchronized serial lines and edge detection
  logic [2:0] lines_s;
  logic [1:0] ctl_prev_q;
  logic       cs_s, sk_s, din_s;
  logic       cs_rise, cs_fall, sk_rise, sk_fall;

  eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_i, sclk_i, din_i}),
    .q_o (lines_s)
  );

  assign cs_s  = lines_s[2];
  assign sk_s  = lines_s[1];
  assign din_s = lines_s[0];

  always_ff @(posedge clk) begin
    if (rst) ctl_prev_q <= '0;
    else     ctl_prev_q <= {cs_s, sk_s};
  end

  assign cs_rise = cs_s & ~ctl_prev_q[1];
  assign cs_fall = ~cs_s & ctl_prev_q[1];
  assign sk_rise = sk_s & ~ctl_prev_q[0];
  assign sk_fall = ~sk_s & ctl_prev_q[0];

  // instruction state
  st_e               state_q;
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wen_q;
  logic              pend_q;
  logic              rel_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              dout_q, doe_q;

  logic [ADDR_FIELD-1:0] addr_full;
  logic [DATA_W-1:0]     rdata;
  logic                  busy;
  logic                  mem_we;

  assign addr_full = {sh_q[ADDR_FIELD-2:0], din_s};
  assign mem_we    = cs_fall & pend_q;

  eep_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (wr_addr_q),
    .wdata_i (wr_data_q),
    .raddr_i (rd_addr_q),
    .rdata_o (rdata)
  );

  eep_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (mem_we),
    .busy_o  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      sh_q      <= '0;
      cnt_q     <= '0;
      wen_q     <= 1'b0;
      pend_q    <= 1'b0;
      rel_q     <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_addr_q <= '0;
      bidx_q    <= '0;
      dout_q    <= 1'b0;
      doe_q     <= 1'b0;
    end else if (cs_fall) begin
      state_q <= S_IDLE;
      doe_q   <= 1'b0;
      dout_q  <= 1'b0;
      rel_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (cs_rise) begin
      rel_q <= 1'b0;
      cnt_q <= '0;
      if (busy) begin
        state_q <= S_STATUS;
        doe_q   <= 1'b1;
        dout_q  <= 1'b0;
      end else begin
        state_q <= S_IDLE;
      end
    end else if (cs_s) begin
      if (state_q == S_STATUS) begin
        dout_q <= ~busy;
        if (sk_rise && din_s) rel_q <= 1'b1;
        if (sk_fall && rel_q) doe_q <= 1'b0;
      end else if (sk_rise) begin
        unique case (state_q)
          S_IDLE: begin
            if (din_s) begin
              state_q <= S_OPC;
              cnt_q   <= '0;
            end
          end
          S_OPC: begin
            op_q <= {op_q[OP_W-2:0], din_s};
            if (cnt_q == CNT_W'(OP_W - 1)) begin
              state_q <= S_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_ADDR: begin
            sh_q <= {sh_q[DATA_W-2:0], din_s};
            if (cnt_q == CNT_W'(ADDR_FIELD - 1)) begin
              cnt_q <= '0;
              unique case (op_e'(op_q))
                OP_READ: begin
                  rd_addr_q <= addr_full[ADDR_W-1:0];
                  bidx_q    <= BIDX_W'(DATA_W - 1);
                  doe_q     <= 1'b1;
                  dout_q    <= 1'b0;
                  state_q   <= S_READ;
                end
                OP_WRITE: begin
                  wr_addr_q <= addr_full[ADDR_W-1:0];
                  state_q   <= wen_q ? S_DATA : S_HOLD;
                end
                OP_ERASE: begin
                  wr_addr_q <= addr_full[ADDR_W-1:0];
                  wr_data_q <= '1;
                  pend_q    <= wen_q;
                  state_q   <= S_HOLD;
                end
                default: begin
                  if (addr_full[ADDR_FIELD-1 -: 2] == 2'b11)      wen_q <= 1'b1;
                  else if (addr_full[ADDR_FIELD-1 -: 2] == 2'b00) wen_q <= 1'b0;
                  state_q <= S_HOLD;
                end
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: begin
            sh_q <= {sh_q[DATA_W-2:0], din_s};
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              wr_data_q <= {sh_q[DATA_W-2:0], din_s};
              pend_q    <= 1'b1;
              state_q   <= S_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_READ: begin
            dout_q <= rdata[bidx_q];
            if (bidx_q == '0) begin
              bidx_q    <= BIDX_W'(DATA_W - 1);
              rd_addr_q <= rd_addr_q + 1'b1;
            end else begin
              bidx_q <= bidx_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_o = dout_q;
  assign doe_o  = doe_q;
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic busy,
  input logic mem_we,
  input logic wen_q,
  input logic dout_o,
  input logic doe_o
);
  // R12: output released once select is seen low
  assert_release_on_deselect_R12: assert property (
    @(posedge clk) disable iff (rst) !cs_s |=> !doe_o);

  // R9: a busy window only opens after a committed store
  assert_busy_after_store_R9: assert property (
    @(posedge clk) disable iff (rst) $rose(busy) |-> $past(mem_we));

  // R9: while selected and busy the status output is low
  assert_status_low_R9: assert property (
    @(posedge clk) disable iff (rst)
      (cs_s && doe_o && busy && $past(busy)) |-> !dout_o);

  // R7: no store while writes are disabled
  assert_store_gated_R7: assert property (
    @(posedge clk) disable iff (rst) mem_we |-> wen_q);

  // R11: no store starts while a previous cycle runs
  assert_no_store_busy_R11: assert property (
    @(posedge clk) disable iff (rst) mem_we |-> !busy);
endmodule

bind sw_eeprom_slave eep_checker u_eep_checker (
  .clk    (clk),
  .rst    (rst),
  .cs_s   (cs_s),
  .busy   (busy),
  .mem_we (mem_we),
  .wen_q  (wen_q),
  .dout_o (dout_o),
  .doe_o  (doe_o)
);

// File: tb/test_sw_eeprom_slave.sv
module test_sw_eeprom_slave;
  localparam int WC = 40;
  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doe;

  always #4 clk = ~clk;

  sw_eeprom_slave #(.WRITE_CYCLES(WC)) i_sw_eeprom_slave (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sk), .din_i(di),
    .dout_o(dout), .doe_o(doe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [512];
  bit          wen_m = 1'b0;

  function automatic logic [15:0] exp_word(input int a);
    return model[a % 512];
  endfunction

  function automatic logic [12:0] mk_cmd(input logic [1:0] op, input logic [9:0] a);
    return {1'b1, op, a};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic o, output logic oe);
    di = b;
    tick(HP);
    sk = 1'b1;
    tick(HP);
    o  = dout;
    oe = doe;
    sk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) xfer(v[i], o, oe);
  endtask

  task automatic select();
    cs = 1'b1;
    tick(HP);
  endtask

  task automatic deselect();
    tick(HP);
    cs = 1'b0;
    tick(HP);
  endtask

  task automatic do_write(input logic [9:0] a, input logic [15:0] d);
    select();
    send_bits(32'(mk_cmd(2'b01, a)), 13);
    send_bits(32'(d), 16);
    deselect();
    tick(WC + 10);
    if (wen_m) model[a[8:0]] = d;
  endtask

  task automatic do_ext(input bit en);
    select();
    send_bits(32'(mk_cmd(2'b00, en ? 10'h300 : 10'h000)), 13);
    deselect();
    wen_m = en;
  endtask

  task automatic do_erase(input logic [9:0] a);
    select();
    send_bits(32'(mk_cmd(2'b11, a)), 13);
    deselect();
    tick(WC + 10);
    if (wen_m) model[a[8:0]] = 16'hFFFF;
  endtask

  task automatic read_words(input logic [9:0] a, input int n, input int zeros, input string req);
    logic [12:0] c;
    logic o, oe;
    logic [15:0] w;
    c = mk_cmd(2'b10, a);
    select();
    send_bits(32'd0, zeros);
    send_bits(32'(c[12:1]), 12);
    xfer(c[0], o, oe);
    check({req, " dummy zero"}, {30'd0, oe, o}, 32'h2);
    for (int k = 0; k < n; k++) begin
      for (int b = 15; b >= 0; b--) begin
        xfer(1'b0, o, oe);
        w[b] = o;
      end
      check(req, {16'd0, w}, {16'd0, exp_word(int'(a[8:0]) + k)});
    end
    deselect();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic o, oe;
    void'($urandom(32'd20240611));
    tick(5);
    rst = 1'b0;
    tick(3);
    check("R1 doe after reset", {31'd0, doe}, 32'd0);

    // R1: write while disabled is dropped
    do_write(10'd5, 16'h1111);
    do_ext(1'b1);
    do_write(10'd5, 16'hAAAA);
    read_words(10'd5, 1, 0, "R3 single read");

    // second reset: enable cleared again
    rst = 1'b1; tick(3); rst = 1'b0; tick(3);
    wen_m = 1'b0;
    check("R1 doe after reset", {31'd0, doe}, 32'd0);
    do_write(10'd5, 16'h1234);
    do_ext(1'b1);
    read_words(10'd5, 1, 0, "R1 write before enable ignored");

    // R5 overwrite without erase
    do_write(10'd5, 16'h5A3C);
    read_words(10'd5, 1, 0, "R5 overwrite");

    // R2 leading zeros and ignored address bit 9
    read_words(10'h205, 1, 3, "R2 framing");

    // R4 sequential with wrap
    do_write(10'd511, 16'h8001);
    do_write(10'd0,   16'h7FFE);
    do_write(10'd1,   16'hC3A5);
    read_words(10'd511, 3, 0, "R4 sequential wrap");

    // R6 erase
    do_erase(10'd0);
    read_words(10'd0, 1, 0, "R6 erase");

    // R7 disable gating
    do_ext(1'b0);
    do_write(10'd1, 16'h0F0F);
    do_erase(10'd1);
    read_words(10'd1, 1, 0, "R7 disabled write/erase");
    do_ext(1'b1);

    // R8 truncated write
    select();
    send_bits(32'(mk_cmd(2'b01, 10'd1)), 13);
    send_bits(32'h00FF, 8);
    deselect();
    tick(WC + 10);
    read_words(10'd1, 1, 0, "R8 truncated write");

    // R9 busy low, R10 release
    select();
    send_bits(32'(mk_cmd(2'b01, 10'd6)), 13);
    send_bits(32'h6666, 16);
    deselect();
    model[6] = 16'h6666;
    select();
    check("R9 busy status", {30'd0, doe, dout}, 32'h2);
    xfer(1'b1, o, oe);
    tick(HP);
    check("R10 release after shifted one", {31'd0, doe}, 32'd0);
    deselect();
    tick(WC);

    // R9 ready status
    select();
    send_bits(32'(mk_cmd(2'b01, 10'd7)), 13);
    send_bits(32'h7777, 16);
    deselect();
    model[7] = 16'h7777;
    select();
    check("R9 busy status", {30'd0, doe, dout}, 32'h2);
    tick(WC + 5);
    check("R9 ready status", {30'd0, doe, dout}, 32'h3);
    deselect();
    check("R12 doe low after deselect", {31'd0, doe}, 32'd0);

    // R11 command while busy
    select();
    send_bits(32'(mk_cmd(2'b01, 10'd3)), 13);
    send_bits(32'h3C3C, 16);
    deselect();
    model[3] = 16'h3C3C;
    select();
    send_bits(32'(mk_cmd(2'b01, 10'd3)), 13);
    send_bits(32'hDEAD, 16);
    deselect();
    tick(WC + 10);
    read_words(10'd3, 1, 0, "R11 command while busy");
    read_words(10'd6, 2, 0, "R4 sequential after status");

    // random writes and reads
    for (int it = 0; it < 12; it++) begin
      logic [9:0]  ra;
      logic [15:0] rd;
      ra = 10'($urandom % 1024);
      rd = 16'($urandom);
      do_write(ra, rd);
      read_words(ra, 1, int'($urandom % 3), "R5 random write/read");
    end

    summary();
    $finish;
  end
endmodule